// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block is a general-purpose interval timer for a processor subsystem. A 16-bit prescaler divides the core clock into count ticks. A 16-bit counter steps up or down on each tick. When the counter passes its end value, it wraps, reloads from an auto-reload value and raises an update event. Each update event sets a sticky status flag. When that flag is enabled, it drives a level interrupt request. A one-cycle update pulse is also brought out for hardware consumers.

Software reaches the timer through a simple synchronous register bus with a 3-bit word address. The auto-reload value can be double-buffered, so a new period takes effect only at the next update event. A new prescale value always waits for the next update event, so a period already in progress is never cut short. Software can:
- force an update event,
- suppress update events entirely, or
- limit the flag to true counter wraps.

The update period is (ARR+1)×(PSC+1) input clocks.

Top module: `interval_timer`

## Requirements
- R1: After reset, the control (offset 0), interrupt-enable (offset 1), status (offset 2), counter (offset 4) and prescale (offset 5) registers read 0. The auto-reload register (offset 6) reads 0xFFFF. The interrupt and the update pulse are low.
- R2: While the enable bit (control bit 0) is 1, the counter moves once every PSC+1 clocks. One full period is (ARR+1)×(PSC+1) clocks.
- R3: With the direction bit (control bit 4) at 0, the counter counts up. When a tick finds the count equal to the active reload value, the counter returns to 0 and an update event occurs.
- R4: With control bit 4 at 1, the counter counts down. When a tick finds the count at 0, the counter loads the reload value and an update event occurs.
- R5: While control bit 0 is 0, neither the counter nor the prescaler advances.
- R6: Every update event sets the flag (status bit 0). Writing status with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged. If a clearing write and a setting event occur in the same cycle, the flag ends up set.
- R7: The interrupt output is high exactly while the flag and the update interrupt enable (interrupt-enable bit 0) are both 1.
- R8: With the preload bit (control bit 7) at 0, a write to offset 6 changes the active reload value at once. With control bit 7 at 1, the written value waits in a buffer until the next update event. A read of offset 6 returns the written value.
- R9: A value written to offset 5 becomes the active prescale value only at the next update event.
- R10: With the update-disable bit (control bit 1) at 1, no update event occurs. The counter still wraps, but it does not set the flag, does not emit a pulse and does not copy the buffers. Forced updates are ignored.
- R11: With the request-source bit (control bit 2) at 1, a forced update still reloads and pulses but does not set the flag. Counter wraps still set the flag.
- R12: Writing bit 0 of the event register (offset 3, which reads 0) forces an update event. The prescaler and the counter restart: the counter goes to 0 when counting up and to the buffered reload value when counting down. The buffered reload and prescale values are loaded. A write to offset 4 in the same cycle takes priority for the counter.
- R13: The update pulse output is high for exactly one clock, in the clock that follows the cycle in which the event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe; read data is 0 when low |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the current register state |
| upd_pulse_o | output | 1 | One-cycle update event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the following corner cases:
- **Wrap boundary, both directions.** An off-by-one there would stretch or shorten every period, and the counter trace read back each cycle would drift from the model.
- **Buffered reload.** A shadow that updated early would change the period in the middle of the current cycle.
- **Delayed prescale.** A prescale applied at once would shift the tick cadence before the next update event.
- **Suppressed updates.** A design that ignored update-disable would still pulse and set the flag while the counter wraps.
- **Source filter.** Under the request-source option, a forced update that set the flag anyway would raise the interrupt, where the model keeps it low.
- **Write-one-no-op on status.** A status write that treated 1 as a clear would drop a pending interrupt.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_IEN  = 3'd1,
        RA_STAT = 3'd2,
        RA_EVG  = 3'd3,
        RA_CNT  = 3'd4,
        RA_PSC  = 3'd5,
        RA_ARR  = 3'd6,
        RA_RSVD = 3'd7
    } reg_addr_e;

    // control bit positions
    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_UDIS = 1;
    localparam int unsigned CB_URS  = 2;
    localparam int unsigned CB_DIR  = 4;
    localparam int unsigned CB_ARPE = 7;

    typedef struct packed {
        logic arpe;
        logic dir;
        logic urs;
        logic udis;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);

    typedef struct packed {
        logic [W-1:0] pc;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.pc == limit_i);
        if (run_i) begin
            st_d.pc = tick_o ? '0 : st_q.pc + W'(1);
        end
        if (clr_i) begin
            st_d.pc = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_PSC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> $stable(st_q.pc)); // R5

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         down_i,
    input  logic [W-1:0] top_i,
    input  logic [W-1:0] reload_i,
    input  logic         ug_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cn_state_t;

    cn_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = tick_i && (down_i ? (st_q.cnt == '0) : (st_q.cnt == top_i));
        if (tick_i) begin
            if (wrap_o)      st_d.cnt = down_i ? reload_i : '0;
            else if (down_i) st_d.cnt = st_q.cnt - W'(1);
            else             st_d.cnt = st_q.cnt + W'(1);
        end
        if (ug_i) begin
            st_d.cnt = down_i ? reload_i : '0;
        end
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !down_i && !wrap_o && !ld_i && !ug_i) |=> (st_q.cnt == $past(st_q.cnt) + W'(1))); // R3
    AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_o && !down_i && !ld_i && !ug_i) |=> (st_q.cnt == '0)); // R3
    AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_o && down_i && !ld_i && !ug_i) |=> (st_q.cnt == $past(reload_i))); // R4

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bus_we_i,
    input  logic          bus_re_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [W-1:0]  bus_wdata_i,
    output logic [W-1:0]  bus_rdata_o,
    output logic          upd_pulse_o,
    output logic          irq_o
);

    typedef struct packed {
        ctrl_t        ctl;
        logic         ie;
        logic         flag;
        logic [W-1:0] arr_buf;
        logic [W-1:0] arr_act;
        logic [W-1:0] psc_buf;
        logic [W-1:0] psc_act;
        logic         pulse;
    } tm_state_t;

    tm_state_t st_d, st_q;

    logic         wr_ctl, wr_ien, wr_stat, wr_cnt, wr_psc, wr_arr;
    logic         ug_req, ug, ev, tick, wrap;
    logic [W-1:0] arr_load, cnt;

    assign wr_ctl  = bus_we_i && (bus_addr_i == RA_CTRL);
    assign wr_ien  = bus_we_i && (bus_addr_i == RA_IEN);
    assign wr_stat = bus_we_i && (bus_addr_i == RA_STAT);
    assign wr_cnt  = bus_we_i && (bus_addr_i == RA_CNT);
    assign wr_psc  = bus_we_i && (bus_addr_i == RA_PSC);
    assign wr_arr  = bus_we_i && (bus_addr_i == RA_ARR);
    assign ug_req  = bus_we_i && (bus_addr_i == RA_EVG) && bus_wdata_i[0];

    assign ug       = ug_req && !st_q.ctl.udis;
    assign ev       = !st_q.ctl.udis && (wrap || ug_req);
    // without an update event the shadow is not refreshed, so reload from the active value
    assign arr_load = st_q.ctl.udis ? st_q.arr_act : st_q.arr_buf;

    itmr_prescaler #(.W(W)) u_psc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.ctl.en),
        .clr_i   (ug),
        .limit_i (st_q.psc_act),
        .tick_o  (tick)
    );

    itmr_counter #(.W(W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .down_i   (st_q.ctl.dir),
        .top_i    (st_q.arr_act),
        .reload_i (arr_load),
        .ug_i     (ug),
        .ld_i     (wr_cnt),
        .ld_val_i (bus_wdata_i),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = ev;

        if (ev) begin
            st_d.arr_act = st_q.arr_buf;
            st_d.psc_act = st_q.psc_buf;
        end

        if (ev && (!st_q.ctl.urs || wrap)) st_d.flag = 1'b1;
        else if (wr_stat && !bus_wdata_i[0]) st_d.flag = 1'b0;

        if (wr_ctl) begin
            st_d.ctl.en   = bus_wdata_i[CB_EN];
            st_d.ctl.udis = bus_wdata_i[CB_UDIS];
            st_d.ctl.urs  = bus_wdata_i[CB_URS];
            st_d.ctl.dir  = bus_wdata_i[CB_DIR];
            st_d.ctl.arpe = bus_wdata_i[CB_ARPE];
        end
        if (wr_ien) st_d.ie      = bus_wdata_i[0];
        if (wr_psc) st_d.psc_buf = bus_wdata_i;
        if (wr_arr) begin
            st_d.arr_buf = bus_wdata_i;
            if (!st_q.ctl.arpe) st_d.arr_act = bus_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.arr_buf <= '1;
            st_q.arr_act <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_re_i) begin
            unique case (bus_addr_i)
                RA_CTRL: begin
                    bus_rdata_o[CB_EN]   = st_q.ctl.en;
                    bus_rdata_o[CB_UDIS] = st_q.ctl.udis;
                    bus_rdata_o[CB_URS]  = st_q.ctl.urs;
                    bus_rdata_o[CB_DIR]  = st_q.ctl.dir;
                    bus_rdata_o[CB_ARPE] = st_q.ctl.arpe;
                end
                RA_IEN:  bus_rdata_o[0] = st_q.ie;
                RA_STAT: bus_rdata_o[0] = st_q.flag;
                RA_CNT:  bus_rdata_o    = cnt;
                RA_PSC:  bus_rdata_o    = st_q.psc_buf;
                RA_ARR:  bus_rdata_o    = st_q.arr_buf;
                default: bus_rdata_o    = '0;
            endcase
        end
    end

    assign upd_pulse_o = st_q.pulse;
    assign irq_o       = st_q.flag && st_q.ie;

    AST_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.flag) |-> $past(ev)); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_pulse_o && !$past(st_q.ctl.urs)) |-> st_q.flag); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> st_q.flag); // R7
    AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ctl.arpe && !ev) |=> $stable(st_q.arr_act)); // R8
    AST_UDIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(st_q.ctl.udis) |-> !upd_pulse_o); // R10

endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we, re;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        pulse, irq;

    always #4 clk = ~clk;

    interval_timer u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_we_i    (we),
        .bus_re_i    (re),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .upd_pulse_o (pulse),
        .irq_o       (irq)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R1";

    // behavioural reference state
    int m_en, m_udis, m_urs, m_dir, m_arpe, m_ie, m_flag, m_pulse;
    int m_cnt, m_pc, m_psc_buf, m_psc_act, m_arr_buf, m_arr_act;

    task automatic model_reset();
        m_en = 0; m_udis = 0; m_urs = 0; m_dir = 0; m_arpe = 0;
        m_ie = 0; m_flag = 0; m_pulse = 0; m_cnt = 0; m_pc = 0;
        m_psc_buf = 0; m_psc_act = 0; m_arr_buf = 'hFFFF; m_arr_act = 'hFFFF;
    endtask

    function automatic int model_rd(int a);
        case (a)
            0: return (m_arpe << 7) | (m_dir << 4) | (m_urs << 2) | (m_udis << 1) | m_en;
            1: return m_ie;
            2: return m_flag;
            4: return m_cnt;
            5: return m_psc_buf;
            6: return m_arr_buf;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int a, d, tick, wrapped, ncnt, npc, ug, ev, old_arpe;
        a = int'(addr); d = int'(wdata);
        tick = (m_en != 0 && m_pc == m_psc_act) ? 1 : 0;
        ncnt = m_cnt; npc = m_pc; wrapped = 0;
        if (m_en != 0) npc = tick ? 0 : ((m_pc + 1) & 'hFFFF);
        if (tick != 0) begin
            if (m_dir == 0) begin
                if (m_cnt == m_arr_act) begin ncnt = 0; wrapped = 1; end
                else ncnt = (m_cnt + 1) & 'hFFFF;
            end else begin
                if (m_cnt == 0) begin wrapped = 1; ncnt = (m_udis != 0) ? m_arr_act : m_arr_buf; end
                else ncnt = m_cnt - 1;
            end
        end
        ug = (we && a == 3 && (d & 1) != 0 && m_udis == 0) ? 1 : 0;
        ev = (m_udis == 0 && (wrapped != 0 || (we && a == 3 && (d & 1) != 0))) ? 1 : 0;
        if (ug != 0) begin npc = 0; ncnt = (m_dir != 0) ? m_arr_buf : 0; end
        if (ev != 0 && (m_urs == 0 || wrapped != 0)) m_flag = 1;
        else if (we && a == 2 && (d & 1) == 0) m_flag = 0;
        if (ev != 0) begin m_arr_act = m_arr_buf; m_psc_act = m_psc_buf; end
        m_pulse = ev;
        old_arpe = m_arpe;
        if (we) begin
            case (a)
                0: begin
                    m_en = d & 1; m_udis = (d >> 1) & 1; m_urs = (d >> 2) & 1;
                    m_dir = (d >> 4) & 1; m_arpe = (d >> 7) & 1;
                end
                1: m_ie = d & 1;
                4: ncnt = d;
                5: m_psc_buf = d;
                6: begin m_arr_buf = d; if (old_arpe == 0) m_arr_act = d; end
                default: ;
            endcase
        end
        m_cnt = ncnt; m_pc = npc;
    endtask

    task automatic check(string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("irq", int'(irq), (m_flag != 0 && m_ie != 0) ? 1 : 0);
        check("pulse", int'(pulse), m_pulse);
        if (re) check("rdata", int'(rdata), model_rd(int'(addr)));
    endtask

    task automatic wr(int a, int d);
        we = 1'b1; re = 1'b0; addr = 3'(a); wdata = 16'(d);
        step();
        we = 1'b0;
    endtask

    task automatic rd(int a);
        re = 1'b1; addr = 3'(a);
        step();
        re = 1'b0;
    endtask

    task automatic run(int n, int a);
        re = 1'b1; addr = 3'(a);
        for (int i = 0; i < n; i++) step();
        re = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        check("irq at reset", int'(irq), 0);
        check("pulse at reset", int'(pulse), 0);
        for (int a = 0; a < 8; a++) rd(a);

        phase = "R12";
        wr(5, 2); wr(6, 4); wr(3, 1); rd(2); rd(5); rd(4);

        phase = "R6";
        wr(2, 1); rd(2); wr(2, 0); rd(2);

        phase = "R2";
        wr(1, 1); wr(0, 'h01); run(20, 4);
        phase = "R3";
        run(25, 4);
        phase = "R6";
        wr(2, 0); run(20, 2);

        phase = "R5";
        wr(0, 'h00); run(12, 4);

        phase = "R4";
        wr(0, 'h11); run(40, 4);

        phase = "R8";
        wr(0, 'h91); wr(6, 2); rd(6); run(30, 4);
        wr(0, 'h01); wr(6, 7); run(30, 4);

        phase = "R9";
        wr(5, 0); run(30, 4);

        phase = "R10";
        wr(0, 'h03); wr(2, 0); run(30, 2); wr(3, 1); run(5, 4);

        phase = "R11";
        wr(0, 'h05); wr(2, 0); wr(3, 1); rd(2); run(30, 2);

        phase = "R13";
        wr(0, 'h00); wr(2, 0); wr(3, 1); run(3, 2);

        phase = "R7";
        wr(1, 0); run(5, 2); wr(1, 1); run(3, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule